// File: doc/BRIEF.md
# Two-Wire Command Frame Receiver

This block sits behind the card contacts of a synchronous memory card and turns the host's serial command traffic into parallel command strobes. The host drives a slow clock line and a shared data line. A frame opens when the data line falls while the clock is high and closes when the data line rises while the clock is high. Between those two conditions the block collects data bits, which the host sends least significant bit first.

When a frame closes, the block checks that exactly three bytes arrived. It treats the first byte as the command code, the second as the address and the third as the operand. If the length is right and the command code is one of the four defined codes, it issues a one-cycle command strobe with a compact opcode, the address and the operand. Any other outcome gives a one-cycle fault strobe, so that the response sequencer can run its fixed fault response.

While the response sequencer reports an active output phase (answer-to-reset, outgoing data or processing), the block does not act on frame conditions. Both contact lines are sampled on the fast system clock through a synchroniser.

Top module: `cmd_frame_rx`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `cmd_valid` and `cmd_fault` are low, and no frame is open.
- R2: A frame opens when `card_io` falls while `card_clk` stays high. It closes when `card_io` rises while `card_clk` stays high.
- R3: Inside a frame, the level of `card_io` at a rising edge of `card_clk` is captured. It counts as a data bit only at the next falling edge of `card_clk`. If a frame condition occurs while the clock is high, the captured level is discarded.
- R4: Bits fill three bytes in the order command code, address, operand, each least significant bit first.
- R5: A frame of exactly 24 bits with a defined command code gives one `cmd_valid` pulse, with `cmd_addr` and `cmd_data` set to the received address and operand. The opcode values are: 0x30 gives 0 (read main), 0x34 gives 1 (read protection), 0x38 gives 2 (update main), 0x3C gives 3 (write protection). `cmd_addr` and `cmd_data` change only together with `cmd_valid`.
- R6: A frame with any bit count other than 24 gives one `cmd_fault` pulse. This includes zero bits and frames far longer than 24 bits.
- R7: A 24-bit frame whose command code is not one of the four defined codes gives one `cmd_fault` pulse and no `cmd_valid`.
- R8: A second opening condition inside a frame restarts the bit count from zero. Only the bits after it form the command.
- R9: While `out_busy` is high, frame conditions are ignored and no strobe follows from them. Bits sent with no frame open are ignored.
- R10: A closing condition with no frame open produces no strobe.
- R11: `cmd_valid` and `cmd_fault` are never high together, and each pulse lasts exactly one system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the card clock |
| rst_n | input | 1 | Synchronous active-low reset |
| card_clk | input | 1 | Card clock line from the host |
| card_io | input | 1 | Data line level as seen at the contact |
| out_busy | input | 1 | High while the response sequencer is in an output phase |
| cmd_valid | output | 1 | One-cycle strobe for a well-formed command |
| cmd_op | output | 2 | Decoded opcode, valid with `cmd_valid` |
| cmd_addr | output | 8 | Received address byte |
| cmd_data | output | 8 | Received operand byte |
| cmd_fault | output | 1 | One-cycle strobe for a faulty frame |

## Verification
The bench builds the block with its default two-stage synchroniser and 8-bit bytes, which makes the frame length 24 bits. The bit counter is 5 bits wide and saturates at 25. With these values, a directed 40-bit frame pushes the counter into saturation and still has to end in a fault. Frame lengths between 0 and 30 drawn at random reach both sides of the exact-length boundary. Every line change is held for four system cycles, so the synchroniser latency stays well inside each clock phase of the card.

// File: rtl/cfr_pkg.sv
// Package for the command frame receiver: byte sizing, command codes,
// the opcode type and the command code decoder.
package cfr_pkg;

    localparam int BYTE_W      = 8;
    localparam int FRAME_BYTES = 3;
    localparam int FRAME_BITS  = BYTE_W * FRAME_BYTES;

    localparam logic [BYTE_W-1:0] CODE_RD_MAIN  = 8'h30;
    localparam logic [BYTE_W-1:0] CODE_RD_PROT  = 8'h34;
    localparam logic [BYTE_W-1:0] CODE_UPD_MAIN = 8'h38;
    localparam logic [BYTE_W-1:0] CODE_WR_PROT  = 8'h3C;

    typedef enum logic [1:0] {
        OP_RD_MAIN  = 2'd0,
        OP_RD_PROT  = 2'd1,
        OP_UPD_MAIN = 2'd2,
        OP_WR_PROT  = 2'd3
    } op_e;

    typedef struct packed {
        logic legal;
        op_e  op;
    } dec_t;

    // Maps a command code to its opcode; legal is low for undefined codes.
    function automatic dec_t decode_code(input logic [BYTE_W-1:0] code);
        dec_t d;
        d.legal = 1'b1;
        d.op    = OP_RD_MAIN;
        case (code)
            CODE_RD_MAIN:  d.op = OP_RD_MAIN;
            CODE_RD_PROT:  d.op = OP_RD_PROT;
            CODE_UPD_MAIN: d.op = OP_UPD_MAIN;
            CODE_WR_PROT:  d.op = OP_WR_PROT;
            default:       d.legal = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/cfr_line_sampler.sv
// Line sampler: synchronises the card clock and data lines to the system
// clock and derives edge and frame-condition events from them.
// Assumes each line level is held for more than SYNC_STAGES+1 system cycles.
module cfr_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic card_clk,
    input  logic card_io,
    output logic io_lvl,
    output logic rise_ev,
    output logic fall_ev,
    output logic open_ev,
    output logic close_ev
);
    localparam int          LINES    = 2;
    localparam logic [1:0]  IDLE_LVL = 2'b10;  // io idles high, clk low

    logic [LINES-1:0] raw;
    logic [LINES-1:0] cur;
    logic [LINES-1:0] prev;

    assign raw = {card_io, card_clk};

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [SYNC_STAGES-1:0] chain;
            // Purpose: shift one line through the synchroniser, then keep its last level.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain   <= {SYNC_STAGES{IDLE_LVL[g]}};
                    prev[g] <= IDLE_LVL[g];
                end else begin
                    chain   <= {chain[SYNC_STAGES-2:0], raw[g]};
                    prev[g] <= chain[SYNC_STAGES-1];
                end
            end
            assign cur[g] = chain[SYNC_STAGES-1];
        end
    endgenerate

    // Purpose: decode clock edges and data-line changes while the clock is high.
    always_comb begin
        io_lvl   = cur[1];
        rise_ev  =  cur[0] & ~prev[0];
        fall_ev  = ~cur[0] &  prev[0];
        open_ev  =  cur[0] &  prev[0] &  prev[1] & ~cur[1];
        close_ev =  cur[0] &  prev[0] & ~prev[1] &  cur[1];
    end

endmodule

// File: rtl/cfr_bit_collector.sv
// Bit collector: tracks the open frame, captures a bit at each rising card
// clock edge, commits it at the falling edge, and reports the frame word
// and whether its length was exact when the frame closes.
// Assumes the events come from cfr_line_sampler, at most one per cycle.
module cfr_bit_collector #(
    parameter int BITS = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            blocked,
    input  logic            io_lvl,
    input  logic            rise_ev,
    input  logic            fall_ev,
    input  logic            open_ev,
    input  logic            close_ev,
    output logic            done,
    output logic            len_ok,
    output logic [BITS-1:0] word
);
    localparam int              CNT_W = $clog2(BITS + 2);
    localparam logic [CNT_W-1:0] EXACT = CNT_W'(BITS);
    localparam logic [CNT_W-1:0] SAT   = CNT_W'(BITS + 1);

    logic             in_frame;
    logic             pend;
    logic             pend_bit;
    logic [CNT_W-1:0] cnt;

    // Purpose: frame state, bit capture and commit, and the end-of-frame report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
            pend     <= 1'b0;
            pend_bit <= 1'b0;
            cnt      <= '0;
            word     <= '0;
            done     <= 1'b0;
            len_ok   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (open_ev && !blocked) begin
                in_frame <= 1'b1;
                cnt      <= '0;
                pend     <= 1'b0;
            end else if (close_ev && !blocked && in_frame) begin
                in_frame <= 1'b0;
                pend     <= 1'b0;
                done     <= 1'b1;
                len_ok   <= (cnt == EXACT);
            end else if (open_ev || close_ev) begin
                pend <= 1'b0;
            end else if (in_frame) begin
                if (rise_ev) begin
                    pend     <= 1'b1;
                    pend_bit <= io_lvl;
                end else if (fall_ev && pend) begin
                    pend <= 1'b0;
                    word <= {pend_bit, word[BITS-1:1]};
                    if (cnt != SAT) begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/cfr_cmd_decode.sv
// Command decoder: on a completed frame, splits the word into its three
// bytes, decodes the command code and registers a command or fault strobe.
// Assumes the word holds the first received bit in bit 0.
module cfr_cmd_decode
    import cfr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  done,
    input  logic                  len_ok,
    input  logic [FRAME_BITS-1:0] word,
    output logic                  cmd_valid,
    output logic [1:0]            cmd_op,
    output logic [BYTE_W-1:0]     cmd_addr,
    output logic [BYTE_W-1:0]     cmd_data,
    output logic                  cmd_fault
);
    logic [BYTE_W-1:0] f_code;
    logic [BYTE_W-1:0] f_addr;
    logic [BYTE_W-1:0] f_data;
    dec_t              dec;

    // Purpose: split the frame word into bytes and decode the command code.
    always_comb begin
        f_code = word[0*BYTE_W +: BYTE_W];
        f_addr = word[1*BYTE_W +: BYTE_W];
        f_data = word[2*BYTE_W +: BYTE_W];
        dec    = decode_code(f_code);
    end

    // Purpose: register the one-cycle strobes and the command fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_fault <= 1'b0;
            cmd_op    <= '0;
            cmd_addr  <= '0;
            cmd_data  <= '0;
        end else begin
            cmd_valid <= done &&  (len_ok && dec.legal);
            cmd_fault <= done && !(len_ok && dec.legal);
            if (done && len_ok && dec.legal) begin
                cmd_op   <= dec.op;
                cmd_addr <= f_addr;
                cmd_data <= f_data;
            end
        end
    end

endmodule

// File: rtl/cmd_frame_rx.sv
// Top of the command frame receiver: sampler, bit collector and decoder.
// Assumes the system clock is much faster than the card clock.
module cmd_frame_rx
    import cfr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_clk,
    input  logic              card_io,
    input  logic              out_busy,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [BYTE_W-1:0] cmd_addr,
    output logic [BYTE_W-1:0] cmd_data,
    output logic              cmd_fault
);
    logic                  io_lvl, rise_ev, fall_ev, open_ev, close_ev;
    logic                  done, len_ok;
    logic [FRAME_BITS-1:0] word;

    cfr_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst_n(rst_n), .card_clk(card_clk), .card_io(card_io),
        .io_lvl(io_lvl), .rise_ev(rise_ev), .fall_ev(fall_ev),
        .open_ev(open_ev), .close_ev(close_ev)
    );

    cfr_bit_collector #(.BITS(FRAME_BITS)) u_collect (
        .clk(clk), .rst_n(rst_n), .blocked(out_busy), .io_lvl(io_lvl),
        .rise_ev(rise_ev), .fall_ev(fall_ev), .open_ev(open_ev),
        .close_ev(close_ev), .done(done), .len_ok(len_ok), .word(word)
    );

    cfr_cmd_decode u_decode (
        .clk(clk), .rst_n(rst_n), .done(done), .len_ok(len_ok), .word(word),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .cmd_fault(cmd_fault)
    );

endmodule

// File: rtl/cfr_checker.sv
// Checker for cmd_frame_rx: strobe shape, reset behaviour, blocking and
// field stability. It is attached to every instance by the bind below.
module cfr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       out_busy,
    input logic       cmd_valid,
    input logic       cmd_fault,
    input logic [7:0] cmd_addr,
    input logic [7:0] cmd_data
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!cmd_valid && !cmd_fault)); // R1
    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(cmd_valid && cmd_fault)); // R11
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |=> !cmd_valid); // R11
    AST_FAULT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) cmd_fault |=> !cmd_fault); // R11
    AST_BUSY_SILENCES: assert property (@(posedge clk) disable iff (!rst_n) $past(out_busy, 2) |-> (!cmd_valid && !cmd_fault)); // R9
    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n) !cmd_valid |-> ($stable(cmd_addr) && $stable(cmd_data))); // R5
endmodule

bind cmd_frame_rx cfr_checker u_cfr_checker (
    .clk(clk), .rst_n(rst_n), .out_busy(out_busy), .cmd_valid(cmd_valid),
    .cmd_fault(cmd_fault), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
);

// File: tb/tb_cmd_frame_rx.sv
module tb_cmd_frame_rx;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 4;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       card_clk = 1'b0;
    logic       card_io = 1'b1;
    logic       out_busy = 1'b0;
    logic       cmd_valid, cmd_fault;
    logic [1:0] cmd_op;
    logic [7:0] cmd_addr, cmd_data;

    int n_tests = 0;
    int n_fail  = 0;
    int n_val   = 0;
    int n_flt   = 0;
    int n_both  = 0;
    int cycles  = 0;
    logic [1:0] cap_op;
    logic [7:0] cap_addr, cap_data;

    cmd_frame_rx dut (
        .clk(clk), .rst_n(rst_n), .card_clk(card_clk), .card_io(card_io),
        .out_busy(out_busy), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_fault(cmd_fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Strobe monitor, sampling away from the active edge.
    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (rst_n) begin
            if (cmd_valid && cmd_fault) n_both <= n_both + 1;
            if (cmd_valid) begin
                n_val    <= n_val + 1;
                cap_op   <= cmd_op;
                cap_addr <= cmd_addr;
                cap_data <= cmd_data;
            end
            if (cmd_fault) n_flt <= n_flt + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic lines(input logic c, input logic d);
        @(negedge clk);
        card_clk = c;
        card_io  = d;
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic send_open();
        lines(1'b0, 1'b1);
        lines(1'b1, 1'b1);
        lines(1'b1, 1'b0);
        lines(1'b0, 1'b0);
    endtask

    task automatic send_bit(input logic b);
        lines(1'b0, b);
        lines(1'b1, b);
        lines(1'b0, b);
    endtask

    task automatic send_close();
        lines(1'b0, 1'b0);
        lines(1'b1, 1'b0);
        lines(1'b1, 1'b1);
        lines(1'b0, 1'b1);
    endtask

    task automatic clear_mon();
        @(negedge clk);
        n_val = 0; n_flt = 0; n_both = 0;
    endtask

    task automatic send_frame(input logic [7:0] c, input logic [7:0] a,
                              input logic [7:0] d, input int nbits);
        logic [23:0] w;
        w = {d, a, c};
        send_open();
        for (int i = 0; i < nbits; i++) begin
            if (i < 24) send_bit(w[i]);
            else        send_bit(1'($urandom));
        end
        send_close();
        repeat (10) @(negedge clk);
    endtask

    // Expected outcome: 0 none, 1 command, 2 fault.
    function automatic int exp_kind(input int nbits, input logic [7:0] c);
        if (nbits != 24) return 2;
        if (c == 8'h30 || c == 8'h34 || c == 8'h38 || c == 8'h3C) return 1;
        return 2;
    endfunction

    function automatic int exp_op(input logic [7:0] c);
        return int'(c[3:2]);
    endfunction

    task automatic run_check(input string req, input logic [7:0] c,
                             input logic [7:0] a, input logic [7:0] d, input int nbits);
        int k;
        clear_mon();
        send_frame(c, a, d, nbits);
        k = exp_kind(nbits, c);
        check({req, " valid count"}, n_val, (k == 1) ? 1 : 0);
        check({req, " fault count"}, n_flt, (k == 2) ? 1 : 0);
        check("R11 no overlap", n_both, 0);
        if (k == 1) begin
            check({req, " R5 op"}, int'(cap_op), exp_op(c));
            check({req, " R4 addr"}, int'(cap_addr), int'(a));
            check({req, " R4 data"}, int'(cap_data), int'(d));
        end
    endtask

    initial begin
        while (cycles < WATCHDOG) @(negedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        check("R1 valid in reset", int'(cmd_valid), 0);
        check("R1 fault in reset", int'(cmd_fault), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 valid after reset", int'(cmd_valid), 0);

        // R5 each defined code, R2/R3 framing, R4 byte order
        run_check("R5 rd_main", 8'h30, 8'hA5, 8'h3C, 24);
        run_check("R5 rd_prot", 8'h34, 8'h01, 8'h80, 24);
        run_check("R5 upd_main", 8'h38, 8'hFF, 8'h00, 24);
        run_check("R5 wr_prot", 8'h3C, 8'h1F, 8'h5A, 24);
        // R7 undefined codes
        run_check("R7 code 31", 8'h31, 8'h10, 8'h20, 24);
        run_check("R7 code 0C", 8'h0C, 8'h10, 8'h20, 24);
        // R6 lengths
        run_check("R6 zero bits", 8'h30, 8'h00, 8'h00, 0);
        run_check("R6 23 bits", 8'h30, 8'h12, 8'h34, 23);
        run_check("R6 25 bits", 8'h30, 8'h12, 8'h34, 25);
        run_check("R6 40 bits saturate", 8'h38, 8'h12, 8'h34, 40);

        // R8 restart inside a frame
        clear_mon();
        send_open();
        for (int i = 0; i < 10; i++) send_bit(1'b1);
        send_frame(8'h34, 8'h77, 8'h99, 24);
        check("R8 valid count", n_val, 1);
        check("R8 fault count", n_flt, 0);
        check("R8 addr", int'(cap_addr), 8'h77);

        // R9 blocked while busy, then R10 lone close
        clear_mon();
        out_busy = 1'b1;
        send_frame(8'h30, 8'h11, 8'h22, 24);
        out_busy = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 no valid while busy", n_val, 0);
        check("R9 no fault while busy", n_flt, 0);
        clear_mon();
        send_close();
        repeat (10) @(negedge clk);
        check("R10 lone close valid", n_val, 0);
        check("R10 lone close fault", n_flt, 0);
        run_check("R9 after busy", 8'h38, 8'h44, 8'h55, 24);

        // Constrained random frames
        for (int t = 0; t < 40; t++) begin
            logic [7:0] c;
            int nb;
            case ($urandom % 6)
                0: c = 8'h30;
                1: c = 8'h34;
                2: c = 8'h38;
                3: c = 8'h3C;
                default: c = 8'($urandom);
            endcase
            nb = (($urandom % 5) == 0) ? int'($urandom % 31) : 24;
            run_check("R5/R6/R7 random", c, 8'($urandom), 8'($urandom), nb);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule